// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block owns the instruction fetch address of a small 8-bit RISC core whose program memory holds 1K words of 13 bits. Each cycle it picks one action from the requests that the decode stage raises: hold, step to the next word, jump, call, return, hardware-interrupt entry or software-trap entry. It then presents the new fetch address on the following clock edge. Jump and call targets span the whole 10-bit space directly, with no page bits.

Any change of program flow costs two cycles. In the cycle after the change the block raises `bubble`. The core uses it to squash the word already in flight. The block ignores every request for the length of that cycle and holds the fetch address.

Calls and interrupt entries save the address that follows the current one on a five-entry hardware stack, and a return pops it. The stack works as a ring. Overflow and underflow are silent and wrap around.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 3FFh and `bubble` is 0. Reset also empties the return stack.
- R2: With `adv` high and no other request, `fetch_addr` rises by one on the next edge, and 3FFh wraps to 000h. With every request low, `fetch_addr` holds its value.
- R3: A `jump` loads `target` into `fetch_addr` on the next edge. Any 10-bit value is allowed.
- R4: A `call` loads `target` and pushes `fetch_addr + 1` (modulo 1024) onto the return stack.
- R5: A `ret` pops the newest stack entry into `fetch_addr`.
- R6: `hw_irq` sends fetch to 008h and pushes `fetch_addr + 1`.
- R7: `sw_trap` sends fetch to 002h and pushes `fetch_addr + 1`.
- R8: When several requests arrive together, one wins and the rest are dropped. The order, highest first, is `hw_irq`, `sw_trap`, `call`, `jump`, `ret`, `adv`.
- R9: After any flow change (R3 to R7), `bubble` is 1 for exactly one cycle. In that cycle `fetch_addr` holds the new address, and every request is ignored without touching the stack.
- R10: The stack keeps 5 entries in a ring. A sixth push overwrites the oldest entry. Pops return the newest five in reverse order. A further pop wraps around the ring and returns the most recently pushed value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv | input | 1 | Step to the next sequential word |
| jump | input | 1 | Jump to `target` |
| call | input | 1 | Call `target` and save the return address |
| ret | input | 1 | Return to the newest saved address |
| hw_irq | input | 1 | Hardware interrupt entry request |
| sw_trap | input | 1 | Software trap entry request |
| target | input | 10 | Jump or call destination |
| fetch_addr | output | 10 | Current program fetch address |
| bubble | output | 1 | Squash cycle after a flow change |

## Verification
The bench builds the block with its default parameters: a 10-bit address, a 5-deep stack, and vectors at 3FFh, 008h and 002h. With these values the bench can reach the 3FFh-to-000h wrap within a few steps, and it can overflow the stack by one using six chained calls. It then unwinds the stack fully and wraps the pointer on the sixth pop. The vector table drives combined requests to expose the priority order. It also places requests inside bubble cycles to show they have no effect.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    // Action selected for the current cycle
    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_SEQ  = 3'd1,
        ACT_JUMP = 3'd2,
        ACT_CALL = 3'd3,
        ACT_RET  = 3'd4,
        ACT_HWI  = 3'd5,
        ACT_SWI  = 3'd6
    } pc_act_e;

    function automatic logic act_is_flow(pc_act_e a);
        return (a != ACT_HOLD) && (a != ACT_SEQ);
    endfunction

    function automatic logic act_is_push(pc_act_e a);
        return (a == ACT_CALL) || (a == ACT_HWI) || (a == ACT_SWI);
    endfunction

endpackage

// File: rtl/pcseq_select.sv
module pcseq_select
    import pcseq_pkg::*;
(
    input  logic    in_bubble,
    input  logic    adv,
    input  logic    jump,
    input  logic    call,
    input  logic    ret,
    input  logic    hw_irq,
    input  logic    sw_trap,
    output pc_act_e act
);

    // Fixed priority: hardware entry, trap, call, jump, return, step (R8)
    always_comb begin
        if (in_bubble)    act = ACT_HOLD;   // squash cycle ignores all (R9)
        else if (hw_irq)  act = ACT_HWI;
        else if (sw_trap) act = ACT_SWI;
        else if (call)    act = ACT_CALL;
        else if (jump)    act = ACT_JUMP;
        else if (ret)     act = ACT_RET;
        else if (adv)     act = ACT_SEQ;
        else              act = ACT_HOLD;
    end

endmodule

// File: rtl/pcseq_retstack.sv
module pcseq_retstack #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DEPTH  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] top_addr
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] slot;
        logic [PTR_W-1:0]             ptr;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [PTR_W-1:0] ptr_inc, ptr_dec;

    // Ring pointer neighbours
    always_comb begin
        ptr_inc = (stk_q.ptr == LAST) ? '0 : stk_q.ptr + 1'b1;
        ptr_dec = (stk_q.ptr == '0) ? LAST : stk_q.ptr - 1'b1;
    end

    assign top_addr = stk_q.slot[ptr_dec];

    always_comb begin
        stk_d = stk_q;
        if (push) begin
            stk_d.slot[stk_q.ptr] = push_addr;   // overwrites oldest when full (R10)
            stk_d.ptr             = ptr_inc;
        end else if (pop) begin
            stk_d.ptr = ptr_dec;                  // wraps when empty (R10)
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    p_ptr_in_ring_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.ptr <= LAST);

    p_push_pop_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

    p_push_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> top_addr == $past(push_addr));

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned DEPTH     = 5,
    parameter int unsigned RESET_VEC = 'h3FF,
    parameter int unsigned HW_VEC    = 'h008,
    parameter int unsigned SW_VEC    = 'h002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              jump,
    input  logic              call,
    input  logic              ret,
    input  logic              hw_irq,
    input  logic              sw_trap,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              bubble
);

    localparam logic [ADDR_W-1:0] RST_A = ADDR_W'(RESET_VEC);
    localparam logic [ADDR_W-1:0] HW_A  = ADDR_W'(HW_VEC);
    localparam logic [ADDR_W-1:0] SW_A  = ADDR_W'(SW_VEC);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              bub;
    } seq_t;

    seq_t              st_d, st_q;
    pc_act_e           act;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] stack_top;
    logic              do_push, do_pop;

    pcseq_select u_select (
        .in_bubble (st_q.bub),
        .adv       (adv),
        .jump      (jump),
        .call      (call),
        .ret       (ret),
        .hw_irq    (hw_irq),
        .sw_trap   (sw_trap),
        .act       (act)
    );

    pcseq_retstack #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_addr (pc_inc),
        .top_addr  (stack_top)
    );

    assign pc_inc  = st_q.pc + 1'b1;   // natural wrap at top of space
    assign do_push = act_is_push(act);
    assign do_pop  = (act == ACT_RET);

    always_comb begin
        st_d     = st_q;
        st_d.bub = act_is_flow(act);
        unique case (act)
            ACT_SEQ:  st_d.pc = pc_inc;
            ACT_JUMP: st_d.pc = target;
            ACT_CALL: st_d.pc = target;
            ACT_RET:  st_d.pc = stack_top;
            ACT_HWI:  st_d.pc = HW_A;
            ACT_SWI:  st_d.pc = SW_A;
            default:  st_d.pc = st_q.pc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pc: RST_A, bub: 1'b0};
        else        st_q <= st_d;
    end

    assign fetch_addr = st_q.pc;
    assign bubble     = st_q.bub;

    p_reset_vec_r1: assert property (@(posedge clk)
        !rst_n |=> (fetch_addr == RST_A) && !bubble);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bubble && adv && !(jump || call || ret || hw_irq || sw_trap))
        |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

    p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bubble && jump && !(call || hw_irq || sw_trap))
        |=> fetch_addr == $past(target));

    p_hw_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bubble && hw_irq) |=> fetch_addr == HW_A);

    p_sw_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bubble && sw_trap && !hw_irq) |=> fetch_addr == SW_A);

    p_bubble_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bubble && (jump || call || ret || hw_irq || sw_trap)) |=> bubble);

    p_bubble_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !bubble && (fetch_addr == $past(fetch_addr)));

endmodule

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adv = 1'b0, jump = 1'b0, call = 1'b0, ret = 1'b0;
    logic       hw_irq = 1'b0, sw_trap = 1'b0;
    logic [9:0] target = '0;
    logic [9:0] fetch_addr;
    logic       bubble;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pc_sequencer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .jump       (jump),
        .call       (call),
        .ret        (ret),
        .hw_irq     (hw_irq),
        .sw_trap    (sw_trap),
        .target     (target),
        .fetch_addr (fetch_addr),
        .bubble     (bubble)
    );

    // Control field order: {adv, jump, call, ret, hw_irq, sw_trap}
    // Entry: {ctrl[5:0], target[9:0], expected addr[9:0], expected bubble}
    localparam logic [26:0] VEC [25] = '{
        {6'b100000, 10'h000, 10'h000, 1'b0},  // wrap 3FF->000
        {6'b100000, 10'h000, 10'h001, 1'b0},
        {6'b000000, 10'h000, 10'h001, 1'b0},  // hold
        {6'b010000, 10'h3FE, 10'h3FE, 1'b1},  // jump
        {6'b010000, 10'h100, 10'h3FE, 1'b0},  // jump inside bubble ignored
        {6'b100000, 10'h000, 10'h3FF, 1'b0},
        {6'b100000, 10'h000, 10'h000, 1'b0},  // wrap again
        {6'b001000, 10'h200, 10'h200, 1'b1},  // call, push 001
        {6'b000100, 10'h000, 10'h200, 1'b0},  // ret inside bubble ignored
        {6'b001011, 10'h050, 10'h008, 1'b1},  // hw wins, push 201
        {6'b100000, 10'h000, 10'h008, 1'b0},  // step inside bubble ignored
        {6'b011001, 10'h123, 10'h002, 1'b1},  // trap wins, push 009
        {6'b000000, 10'h000, 10'h002, 1'b0},
        {6'b011100, 10'h0AA, 10'h0AA, 1'b1},  // call wins, push 003
        {6'b000000, 10'h000, 10'h0AA, 1'b0},
        {6'b010100, 10'h155, 10'h155, 1'b1},  // jump beats ret
        {6'b000000, 10'h000, 10'h155, 1'b0},
        {6'b000100, 10'h000, 10'h003, 1'b1},
        {6'b000000, 10'h000, 10'h003, 1'b0},
        {6'b000100, 10'h000, 10'h009, 1'b1},
        {6'b000000, 10'h000, 10'h009, 1'b0},
        {6'b000100, 10'h000, 10'h201, 1'b1},
        {6'b000000, 10'h000, 10'h201, 1'b0},
        {6'b000100, 10'h000, 10'h001, 1'b1},
        {6'b000000, 10'h000, 10'h001, 1'b0}
    };

    task automatic drive(input logic [5:0] c, input logic [9:0] t);
        {adv, jump, call, ret, hw_irq, sw_trap} = c;
        target = t;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [9:0] ea, input logic eb);
        n_vec++;
        if (fetch_addr !== ea || bubble !== eb) begin
            n_bad++;
            $display("FAIL %s: fetch_addr=%h bubble=%b expected fetch_addr=%h bubble=%b",
                     tag, fetch_addr, bubble, ea, eb);
        end
    endtask

    function automatic string tag_of(input logic [5:0] c, input logic prev_b);
        if (prev_b)                 return "R9";
        if ($countones(c[4:0]) > 1) return "R8";
        if (c[1])                   return "R6";
        if (c[0])                   return "R7";
        if (c[3])                   return "R4";
        if (c[4])                   return "R3";
        if (c[2])                   return "R5";
        return "R2";
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin : main
        logic [9:0] saved [6];
        logic       prev_b;
        drive(6'b0, '0);
        repeat (3) tick();
        check("R1", 10'h3FF, 1'b0);
        rst_n  = 1'b1;
        prev_b = 1'b0;

        for (int i = 0; i < 25; i++) begin
            drive(VEC[i][26:21], VEC[i][20:11]);
            tick();
            check(tag_of(VEC[i][26:21], prev_b), VEC[i][10:1], VEC[i][0]);
            prev_b = VEC[i][0];
        end
        drive(6'b0, '0);

        // R10: six chained calls overflow the 5-entry ring by one
        for (int i = 0; i < 6; i++) begin
            logic [9:0] dst;
            dst      = 10'h040 + 10'(i * 16);
            saved[i] = fetch_addr + 10'd1;
            drive(6'b001000, dst);
            tick();
            check("R4", dst, 1'b1);
            drive(6'b0, '0);
            tick();
            check("R9", dst, 1'b0);
        end
        for (int k = 0; k < 6; k++) begin
            int idx;
            idx = (k < 5) ? 5 - k : 5;
            drive(6'b000100, '0);
            tick();
            check("R10", saved[idx], 1'b1);
            drive(6'b0, '0);
            tick();
            check("R10", saved[idx], 1'b0);
        end

        // R1: reset in mid-run
        drive(6'b100000, '0);
        tick();
        rst_n = 1'b0;
        tick();
        check("R1", 10'h3FF, 1'b0);
        rst_n = 1'b1;
        tick();
        check("R2", 10'h000, 1'b0);
        drive(6'b0, '0);

        summary();
        $finish;
    end

endmodule